// File: doc/BRIEF.md
# Saturating Doubling Add/Subtract Unit

This unit is a signed two's-complement arithmetic stage for a small processor datapath. It takes two operands, called M and N, and a two-bit operation code. It returns M plus or minus a possibly doubled N, and clamps every intermediate that leaves the signed range to the nearest extreme instead of letting it wrap.

Saturation can happen in two places. The first is the optional doubling of N. The second is the final add or subtract. Either one sets a sticky overflow flag. That flag stays high over any number of later operations until software-visible logic pulses the clear input.

The result is registered, with a latency of one clock. A valid strobe marks each accepted operation, and a matching output strobe marks each result.

Top module: `qsat_alu`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `res_valid` is high for the following cycle. When `in_valid` is low at an edge, `res_valid` is low for the following cycle.
- R2: `op[0]` selects the arithmetic: 0 is add and 1 is subtract. `op[1]` selects doubling of N: 0 is off and 1 is on. The two bits are independent. With `op` = 2'b00 the result is M + N, when that sum is in range.
- R3: With `op[0]` = 1, N (or doubled N) is the subtrahend, so the result is M − f(N), when that difference is in range.
- R4: With `op[1]` = 1, if N ≥ 2^30 (for example 0x40000000), then f(N) = 0x7FFFFFFF and the sticky flag is set.
- R5: With `op[1]` = 1, if N < −2^30, then f(N) = 0x80000000 and the sticky flag is set. N = 0xC0000000 doubles exactly to 0x80000000 and does not set the flag. Any other N is shifted left by one bit.
- R6: If the final add or subtract falls outside the signed 32-bit range, the result is 0x7FFFFFFF (positive overflow) or 0x80000000 (negative overflow), and the sticky flag is set.
- R7: `q_flag` stays high until a cycle in which `q_clear` is high. A clear lowers it unless a saturating operation is accepted in the same cycle; in that case the flag stays set.
- R8: While `rst_n` is low, `res_valid`, `q_flag` and `res_data` are all zero.
- R9: `res_data` keeps its last value across any cycle in which `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted at this edge |
| op | input | 2 | bit0 = subtract, bit1 = double N |
| opnd_m | input | 32 | M operand (minuend / addend) |
| opnd_n | input | 32 | N operand (may be doubled) |
| q_clear | input | 1 | Clears the sticky saturation flag |
| res_data | output | 32 | Registered saturated result |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Directed vectors place N exactly on and just beside the doubling thresholds (0x3FFFFFFF, 0x40000000, 0xC0000000, 0xBFFFFFFF). These separate a correct two-top-bit test from a comparison that is off by one, and they show that an exactly representable −2^31 leaves the flag clear. Add and subtract operands that sit at the signed extremes separate positive from negative clamping and check which operand is the subtrahend. Random mixes of all four codes, with idle gaps and clear pulses, exercise flag stickiness, the priority of set over clear, and the output holding its value while idle. A behavioural model that works in wide integers is compared with the outputs on every cycle.

// File: rtl/qsat_pkg.sv
package qsat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } qsat_op_e;
endpackage

// File: rtl/qsat_doubler.sv
module qsat_doubler #(
  parameter int WIDTH = 32
) (
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             sat
);
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic lose_bit;

  // Doubling is exact only when the two top bits agree.
  always_comb begin
    lose_bit = din[WIDTH-1] ^ din[WIDTH-2];
    sat      = en & lose_bit;
    if (!en)
      dout = din;
    else if (!lose_bit)
      dout = {din[WIDTH-2:0], 1'b0};
    else if (din[WIDTH-1])
      dout = MAX_NEG;
    else
      dout = MAX_POS;
  end
endmodule

// File: rtl/qsat_addsub.sv
module qsat_addsub #(
  parameter int WIDTH = 32
) (
  input  logic             sub,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y,
  output logic             sat
);
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH:0] a_x, b_x, wide;

  // One guard bit: the result left the range when the guard and sign differ.
  always_comb begin
    a_x  = {a[WIDTH-1], a};
    b_x  = {b[WIDTH-1], b};
    wide = sub ? (a_x - b_x) : (a_x + b_x);
    sat  = wide[WIDTH] ^ wide[WIDTH-1];
    if (!sat)
      y = wide[WIDTH-1:0];
    else if (wide[WIDTH])
      y = MAX_NEG;
    else
      y = MAX_POS;
  end
endmodule

// File: rtl/qsat_alu.sv
module qsat_alu
  import qsat_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opnd_m,
  input  logic [WIDTH-1:0] opnd_n,
  input  logic             q_clear,
  output logic [WIDTH-1:0] res_data,
  output logic             res_valid,
  output logic             q_flag
);
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] n_eff, sum_y;
  logic             dbl_sat, as_sat;
  logic [WIDTH-1:0] data_d;
  logic             valid_d, q_d, data_en;

  qsat_doubler #(.WIDTH(WIDTH)) u_dbl (
    .en   (op[1]),
    .din  (opnd_n),
    .dout (n_eff),
    .sat  (dbl_sat)
  );

  qsat_addsub #(.WIDTH(WIDTH)) u_as (
    .sub (op[0]),
    .a   (opnd_m),
    .b   (n_eff),
    .y   (sum_y),
    .sat (as_sat)
  );

  // next state
  always_comb begin
    data_en = in_valid;
    data_d  = sum_y;
    valid_d = in_valid;
    q_d     = (q_flag & ~q_clear) | (in_valid & (dbl_sat | as_sat));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_valid <= 1'b0;
      q_flag    <= 1'b0;
    end else begin
      if (data_en) res_data <= data_d;
      res_valid <= valid_d;
      q_flag    <= q_d;
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  // R1
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  // R7
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clear) |=> q_flag);
  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data));
  // R4
  dbl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DADD && opnd_m == '0 && !opnd_n[WIDTH-1] && opnd_n[WIDTH-2])
      |=> (res_data == MAX_POS && q_flag));
endmodule

// File: tb/qsat_alu_tb_top.sv
module qsat_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [31:0] opnd_m, opnd_n;
  logic        q_clear;
  logic [31:0] res_data;
  logic        res_valid, q_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [31:0] e_data;
  logic        e_valid, e_q;
  string       e_tag;

  always #10 clk = ~clk;

  qsat_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_m(opnd_m), .opnd_n(opnd_n), .q_clear(q_clear),
    .res_data(res_data), .res_valid(res_valid), .q_flag(q_flag)
  );

  function automatic longint clampw(longint v, output bit hit);
    hit = 1'b0;
    if (v > 64'sd2147483647)       begin hit = 1'b1; return 64'sd2147483647; end
    if (v < -64'sd2147483648)      begin hit = 1'b1; return -64'sd2147483648; end
    return v;
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_data = 0; e_valid = 0; e_q = 0; e_tag = "R8";
    end else begin
      bit h1, h2;
      longint nv, r;
      h1 = 0; h2 = 0;
      nv = longint'($signed(opnd_n));
      if (op[1]) nv = clampw(nv * 2, h1);
      r = op[0] ? longint'($signed(opnd_m)) - nv : longint'($signed(opnd_m)) + nv;
      r = clampw(r, h2);
      e_q = (e_q && !q_clear) || (in_valid && (h1 || h2));
      e_valid = in_valid;
      if (in_valid) begin
        e_data = r[31:0];
        e_tag = h1 ? (nv > 0 ? "R4" : "R5") : h2 ? "R6" : op[0] ? "R3" : "R2";
        if (op[1] && !h1 && opnd_n == 32'hC000_0000) e_tag = "R5";
      end else e_tag = "R9";
    end
  end

  task automatic check_all();
    n_tests++;
    if (res_valid !== e_valid) begin
      n_fail++; $display("FAIL R1 res_valid act=%0b exp=%0b", res_valid, e_valid);
    end
    n_tests++;
    if (res_data !== e_data) begin
      n_fail++; $display("FAIL %s res_data act=%h exp=%h", e_tag, res_data, e_data);
    end
    n_tests++;
    if (q_flag !== e_q) begin
      n_fail++; $display("FAIL R7 q_flag act=%0b exp=%0b (case %s)", q_flag, e_q, e_tag);
    end
  endtask

  // drive at falling edge, check the previous edge's result first
  task automatic step(input bit v, input logic [1:0] o, input logic [31:0] m,
                      input logic [31:0] n, input bit clr);
    @(negedge clk);
    check_all();
    in_valid = v; op = o; opnd_m = m; opnd_n = n; q_clear = clr;
  endtask

  task automatic clear_q();
    step(0, 2'b00, 0, 0, 1);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; op = 0; opnd_m = 0; opnd_n = 0; q_clear = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    n_tests++;
    if (res_valid !== 0 || q_flag !== 0 || res_data !== 0) begin
      n_fail++; $display("FAIL R8 reset act=%0b/%0b/%h exp=0/0/0", res_valid, q_flag, res_data);
    end
    rst_n = 1;
    // R2 / R3 plain
    step(1, 2'b00, 32'd5, 32'd7, 0);
    step(1, 2'b01, 32'd5, 32'd7, 0);
    // R4 doubling boundary
    step(1, 2'b10, 0, 32'h3FFF_FFFF, 0);
    step(1, 2'b10, 0, 32'h4000_0000, 0);
    clear_q();
    // R5 exact -2^30 then just below
    step(1, 2'b10, 0, 32'hC000_0000, 0);
    step(0, 2'b00, 0, 0, 0);
    step(1, 2'b10, 0, 32'hBFFF_FFFF, 0);
    clear_q();
    // R3 doubled subtrahend
    step(1, 2'b11, 32'd100, 32'd20, 0);
    // R6 add/sub overflow both ways
    step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 0);
    clear_q();
    step(1, 2'b01, 32'h8000_0000, 32'd1, 0);
    clear_q();
    step(1, 2'b01, 32'd0, 32'h8000_0000, 0);
    // R7 sticky across clean ops, then set beats clear
    step(1, 2'b00, 1, 1, 0);
    step(0, 2'b00, 0, 0, 0);
    step(1, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1);
    clear_q();
    // R9 idle hold
    step(1, 2'b00, 32'd9, 32'd9, 0);
    step(0, 2'b01, 32'd1, 32'd2, 0);
    step(0, 2'b11, 32'h7000_0000, 32'h8000_0000, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] m, n;
      m = $urandom; n = $urandom;
      if ($urandom_range(0, 3) == 0) n = {n[31], ~n[31], 30'($urandom_range(0, 3))};
      step($urandom_range(0, 3) != 0, 2'($urandom), m, n, $urandom_range(0, 9) == 0);
    end
    step(0, 2'b00, 0, 0, 0);
    @(negedge clk);
    check_all();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog act=%0d exp<=20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule